// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Interface Controller

This block is an 8-bit SPI peripheral for a small processor bus. Software reaches it through three registers: control, status and data. It can act as the clock-driving master or as a slave clocked from outside. The control register selects the following at run time:

- whether the block is enabled;
- whether it is master or slave;
- the bit order on the wire;
- the idle level of the serial clock;
- which clock edge samples and which edge shifts;
- the master clock rate.

In master mode, a write to the data register while the block is idle sends one byte. The block generates sixteen serial clock edges, and every edge of the sequence is fully regular. In slave mode, the block shifts while the external select line is low. The incoming clock, data and select lines pass through two-flop synchronisers first.

When a byte completes, the block sets a sticky completion flag and stores the received byte in the data register for reading. The interrupt request follows that flag, gated by the local enable bit and by an external serial-interrupt enable input. A data write during a transfer sets a sticky collision flag and leaves the outgoing byte untouched. Both flags are cleared only by software writes to the status register.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, the data register reads 0x00, `irq` is low and all three output enables are low.
- R2: Address 0 is the control register with bit 7 interrupt enable, bit 6 block enable, bit 5 LSB-first, bit 4 master, bit 3 clock polarity, bit 2 clock phase and bits 1:0 rate select; it reads back as written. Address 1 is status with bit 7 completion and bit 6 collision, other bits reading 0. Address 2 writes the byte to send and reads the last received byte. Address 3 reads 0.
- R3: With the block enabled as master, a data write while idle starts a transfer that produces exactly 16 `sck_o` transitions and then stops.
- R4: With LSB-first = 0 the byte is shifted MSB first; with LSB-first = 1 it is shifted LSB first; the same order applies to the received byte.
- R5: With polarity 0, SCK rests low between transfers; with polarity 1 it rests high.
- R6: With phase 0, data is sampled on each leading SCK edge and the output changes on trailing edges; with phase 1, sampling is on trailing edges and the output changes on leading edges. The bits sampled on `miso_i` form the received byte.
- R7: In master mode, rate codes 0, 1, 2 and 3 give an SCK period of 4, 16, 64 and 128 system clocks, so consecutive SCK transitions are 2, 8, 32 and 64 clocks apart.
- R8: The completion flag (status bit 7) is set when a byte finishes. Writing 1 to status bit 7 clears it, and writing 0 leaves it set.
- R9: A data write while a transfer is in progress sets the collision flag (status bit 6) and does not alter the byte being sent. Writing 1 to status bit 6 clears that flag only.
- R10: `irq` is high exactly when the completion flag, control bit 7 and `ser_irq_en` are all set.
- R11: Clearing the enable bit drives all output enables low and aborts any transfer without setting the completion flag. After re-enabling, a new transfer starts normally.
- R12: In slave mode, `miso_oe` is high only while the synchronised select is low, and `sck_oe` and `mosi_oe` stay low. The block receives on `mosi_i` and sends on `miso_o` in the selected mode. Raising select mid-byte discards the partial byte without setting the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ser_irq_en | input | 1 | External serial interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for `sck_o` |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Output enable for `mosi_o` |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Output enable for `miso_o` |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench plays the far end of the link in all four polarity and phase combinations and in both bit orders. It checks the MOSI sequence and the received byte. A design with swapped sample and shift edges would return a byte offset by one bit, and a design with a wrong rate decode would show SCK intervals other than 2, 8, 32 or 64 clocks. A write in the middle of a transfer must leave the transmitted bits intact and set only the collision flag. Clearing enable mid-byte must leave no hung busy state, which would otherwise show up as a false collision on the next transfer. A slave byte cut short by select must not leak stale bits into the following byte.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } spi_ctl_t;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int HALF_W = 7;

  // system clocks per SCK half period for each rate code
  function automatic logic [HALF_W-1:0] sck_half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    return HALF_W'(2);
      2'd1:    return HALF_W'(8);
      2'd2:    return HALF_W'(32);
      default: return HALF_W'(64);
    endcase
  endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       cpol,
  input  logic [1:0] rate,
  output logic       sck,
  output logic       tick,
  output logic       lead
);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_m1;

  assign half_m1 = sck_half_period(rate) - HALF_W'(1);
  assign tick    = run && (cnt == half_m1);
  assign lead    = tick && (sck == cpol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= cpol;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end

  // R7: edges are never back to back
  p_tick_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R5: SCK returns to the polarity level whenever not running
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sck == $past(cpol)));

endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic ss_n_i,
  input  logic cpol,
  output logic edge_p,
  output logic lead,
  output logic mosi_s,
  output logic ss_s
);

  logic [SYNC-1:0] sck_q;
  logic [SYNC-1:0] mosi_q;
  logic [SYNC-1:0] ss_q;
  logic            sck_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q    <= '0;
      mosi_q   <= '0;
      ss_q     <= '1;
      sck_prev <= 1'b0;
    end else begin
      sck_q    <= {sck_q[SYNC-2:0], sck_i};
      mosi_q   <= {mosi_q[SYNC-2:0], mosi_i};
      ss_q     <= {ss_q[SYNC-2:0], ss_n_i};
      sck_prev <= sck_q[SYNC-1];
    end
  end

  assign ss_s   = ss_q[SYNC-1];
  assign mosi_s = mosi_q[SYNC-1];
  assign edge_p = (sck_q[SYNC-1] != sck_prev) && !ss_s;
  assign lead   = (sck_q[SYNC-1] != cpol);

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_p,
  input  logic          lead,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          in_bit,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          abort,
  output logic          tx_bit,
  output logic [DW-1:0] shreg,
  output logic          done,
  output logic          active
);

  localparam int CW = $clog2(2 * DW);

  logic [CW-1:0] cnt;
  logic          sample_e;
  logic          shift_e;

  function automatic logic out_pos(input logic [DW-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DW-1];
  endfunction

  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] v, input logic b,
                                             input logic lsb);
    return lsb ? {b, v[DW-1:1]} : {v[DW-2:0], b};
  endfunction

  assign sample_e = edge_p && (lead != cpha);
  assign shift_e  = edge_p && (lead == cpha);
  assign done     = edge_p && (cnt == CW'(2 * DW - 1));
  assign active   = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      shreg  <= '0;
      tx_bit <= 1'b0;
    end else if (load) begin
      cnt    <= '0;
      shreg  <= load_data;
      tx_bit <= out_pos(load_data, lsb_first);
    end else if (abort) begin
      cnt    <= '0;
      tx_bit <= out_pos(shreg, lsb_first);
    end else begin
      if (edge_p) cnt <= done ? '0 : cnt + CW'(1);
      if (sample_e) shreg <= shift_in(shreg, in_bit, lsb_first);
      if (shift_e || (!edge_p && !active)) tx_bit <= out_pos(shreg, lsb_first);
    end
  end

  // R9: the top never reloads the shifter in the middle of a byte
  p_load_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);

endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ser_irq_en,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i
);

  spi_ctl_t      ctl;
  logic          spif, wcol, mbusy, done_q;
  logic [DW-1:0] rx_buf;

  logic wr_ctl, wr_stat, wr_data;
  logic is_master, is_slave, busy, load, collide, xfer_done;
  logic m_sck, m_tick, m_lead;
  logic s_edge, s_lead, mosi_s, ss_s;
  logic c_edge, c_lead, c_in, c_abort, c_active, tx_bit;
  logic [DW-1:0] shreg;

  assign wr_ctl    = bus_wr && (bus_addr == A_CTL);
  assign wr_stat   = bus_wr && (bus_addr == A_STAT);
  assign wr_data   = bus_wr && (bus_addr == A_DATA);
  assign is_master = ctl.enable && ctl.master;
  assign is_slave  = ctl.enable && !ctl.master;
  assign busy      = mbusy || c_active;
  assign load      = wr_data && !busy;
  assign collide   = wr_data && busy;

  spi_sck_gen u_sck_gen (
    .clk (clk), .rst_n (rst_n), .run (is_master && mbusy), .cpol (ctl.cpol),
    .rate (ctl.rate), .sck (m_sck), .tick (m_tick), .lead (m_lead)
  );

  spi_slave_front #(.SYNC(SYNC)) u_front (
    .clk (clk), .rst_n (rst_n), .sck_i (sck_i), .mosi_i (mosi_i), .ss_n_i (ss_n_i),
    .cpol (ctl.cpol), .edge_p (s_edge), .lead (s_lead), .mosi_s (mosi_s), .ss_s (ss_s)
  );

  assign c_edge  = is_master ? m_tick : (is_slave && s_edge);
  assign c_lead  = is_master ? m_lead : s_lead;
  assign c_in    = is_master ? miso_i : mosi_s;
  assign c_abort = !ctl.enable || (is_slave && ss_s);

  spi_shift_core #(.DW(DW)) u_core (
    .clk (clk), .rst_n (rst_n), .edge_p (c_edge), .lead (c_lead), .cpha (ctl.cpha),
    .lsb_first (ctl.lsb_first), .in_bit (c_in), .load (load), .load_data (bus_wdata),
    .abort (c_abort), .tx_bit (tx_bit), .shreg (shreg), .done (xfer_done),
    .active (c_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= '0;
      spif   <= 1'b0;
      wcol   <= 1'b0;
      mbusy  <= 1'b0;
      done_q <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (wr_ctl) ctl <= spi_ctl_t'(bus_wdata[7:0]);
      done_q <= xfer_done;
      if (done_q) rx_buf <= shreg;
      if (!is_master)     mbusy <= 1'b0;
      else if (load)      mbusy <= 1'b1;
      else if (xfer_done) mbusy <= 1'b0;
      if (done_q)                       spif <= 1'b1;
      else if (wr_stat && bus_wdata[7]) spif <= 1'b0;
      if (collide)                      wcol <= 1'b1;
      else if (wr_stat && bus_wdata[6]) wcol <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = DW'(ctl);
      A_STAT:  bus_rdata = DW'({spif, wcol, 6'b0});
      A_DATA:  bus_rdata = rx_buf;
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = spif && ctl.irq_en && ser_irq_en;
  assign sck_o   = m_sck;
  assign sck_oe  = is_master;
  assign mosi_o  = tx_bit;
  assign mosi_oe = is_master;
  assign miso_o  = tx_bit;
  assign miso_oe = is_slave && !ss_s;

  // R8: completion flag only rises after the shifter reports the last edge
  p_flag_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(xfer_done, 2));

  // R9: a collision write is remembered in the status flag
  p_collide_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> wcol);

  // R10: no request without the local enable bit
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.irq_en |-> !irq);

  // R11: disabling clears every trace of an ongoing transfer
  p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.enable |=> !busy);

  // R12: a deselected slave stays idle
  p_ss_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(is_slave) && is_slave && $past(ss_s) && ss_s) |-> !busy);

endmodule

// File: tb/test_spi_port_ctrl.sv
module test_spi_port_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ser_irq_en = 1'b0;
  logic       irq;
  logic       sck_i = 1'b0, sck_o, sck_oe;
  logic       mosi_i = 1'b0, mosi_o, mosi_oe;
  logic       miso_i = 1'b0, miso_o, miso_oe;
  logic       ss_n_i = 1'b1;

  int n_checks = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  spi_port_ctrl i_spi_port_ctrl (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .ser_irq_en (ser_irq_en), .irq (irq),
    .sck_i (sck_i), .sck_o (sck_o), .sck_oe (sck_oe), .mosi_i (mosi_i), .mosi_o (mosi_o),
    .mosi_oe (mosi_oe), .miso_i (miso_i), .miso_o (miso_o), .miso_oe (miso_oe),
    .ss_n_i (ss_n_i)
  );

  function automatic logic bit_at(logic [7:0] b, int i, logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  function automatic int half_of(logic [1:0] r);
    return (r == 2'd3) ? 64 : (2 << (2 * r));
  endfunction

  function automatic logic [7:0] ctl_word(logic ie, logic en, logic lsb, logic mst,
                                          logic cpol, logic cpha, logic [1:0] rate);
    return {ie, en, lsb, mst, cpol, cpha, rate};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic master_xfer(logic [7:0] tx, logic [7:0] pat, logic cpol, logic cpha,
                             logic lsb, logic [1:0] rate, int coll_at, logic [7:0] coll_byte);
    logic [7:0] seen, expv, rd;
    int tog, since, nb, bad_iv;
    logic prev;
    bit coll_done;
    bus_write(2'd0, ctl_word(1'b0, 1'b1, lsb, 1'b1, cpol, cpha, rate));
    bus_write(2'd1, 8'hC0);
    chk(sck_o == cpol, "R5 idle SCK before transfer", sck_o, cpol);
    miso_i = bit_at(pat, 0, lsb);
    bus_write(2'd2, tx);
    prev = cpol; tog = 0; since = 0; nb = 0; bad_iv = 0; seen = 8'h00; coll_done = 0;
    for (int cyc = 0; cyc < 4000 && tog < 16; cyc++) begin
      if (coll_at >= 0 && tog == coll_at && !coll_done) begin
        bus_addr = 2'd2; bus_wdata = coll_byte; bus_wr = 1'b1; coll_done = 1;
      end
      step(1);
      bus_wr = 1'b0;
      since++;
      if (sck_o !== prev) begin
        if (tog > 0 && since != half_of(rate)) bad_iv++;
        if (((sck_o != cpol) != cpha) && nb < 8) begin
          seen[nb] = mosi_o;
          nb++;
        end
        tog++; since = 0; prev = sck_o;
        if (tog < 16) miso_i = bit_at(pat, tog / 2, lsb);
      end
    end
    step(3);
    for (int i = 0; i < 8; i++) expv[i] = bit_at(tx, i, lsb);
    chk(tog == 16, "R3 SCK transition count", tog, 16);
    chk(bad_iv == 0, "R7 SCK half period", bad_iv, 0);
    chk(seen == expv, "R4 R6 MOSI bit sequence", seen, expv);
    bus_read(2'd2, rd);
    chk(rd == pat, "R6 received byte", rd, pat);
    bus_read(2'd1, rd);
    chk(rd[7] == 1'b1, "R8 completion flag", rd[7], 1);
    chk(rd[6] == (coll_at >= 0), "R9 collision flag", rd[6], (coll_at >= 0));
    chk(sck_o == cpol, "R5 idle SCK after transfer", sck_o, cpol);
  endtask

  task automatic slave_xfer(logic [7:0] mb, logic [7:0] sb, logic cpol, logic cpha,
                            logic lsb, logic [1:0] rate);
    localparam int H = 8;
    logic [7:0] got, expv, rd;
    ss_n_i = 1'b1; sck_i = cpol; mosi_i = 1'b0;
    bus_write(2'd0, ctl_word(1'b0, 1'b1, lsb, 1'b0, cpol, cpha, rate));
    step(4);
    bus_write(2'd1, 8'hC0);
    bus_write(2'd2, sb);
    chk(miso_oe == 1'b0, "R12 MISO released while deselected", miso_oe, 0);
    ss_n_i = 1'b0;
    step(4);
    chk(miso_oe == 1'b1, "R12 MISO driven while selected", miso_oe, 1);
    chk(!sck_oe && !mosi_oe, "R12 master pins released", {sck_oe, mosi_oe}, 0);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) mosi_i = bit_at(mb, i, lsb);
      step(H);
      if (!cpha) got[i] = miso_o;
      sck_i = ~cpol;
      if (cpha) mosi_i = bit_at(mb, i, lsb);
      step(H);
      if (cpha) got[i] = miso_o;
      sck_i = cpol;
    end
    step(H);
    ss_n_i = 1'b1;
    step(4);
    for (int i = 0; i < 8; i++) expv[i] = bit_at(sb, i, lsb);
    chk(got == expv, "R12 R4 slave MISO sequence", got, expv);
    bus_read(2'd2, rd);
    chk(rd == mb, "R12 slave received byte", rd, mb);
    bus_read(2'd1, rd);
    chk(rd[7] == 1'b1, "R8 slave completion flag", rd[7], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] rd, v;
    void'($urandom(32'h5A17));
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    bus_read(2'd0, rd); chk(rd == 8'h00, "R1 control after reset", rd, 0);
    bus_read(2'd1, rd); chk(rd == 8'h00, "R1 status after reset", rd, 0);
    bus_read(2'd2, rd); chk(rd == 8'h00, "R1 data after reset", rd, 0);
    chk(!irq && !sck_oe && !mosi_oe && !miso_oe, "R1 outputs after reset",
        {irq, sck_oe, mosi_oe, miso_oe}, 0);

    // R2 register map
    v = 8'h9B;
    bus_write(2'd0, v);
    bus_read(2'd0, rd); chk(rd == v, "R2 control readback", rd, v);
    bus_read(2'd3, rd); chk(rd == 8'h00, "R2 unused address", rd, 0);
    bus_write(2'd0, 8'h00);

    // directed master cases, all four clock modes
    master_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 2'd0, -1, 8'h00);
    master_xfer(8'h81, 8'h7E, 1'b1, 1'b0, 1'b1, 2'd1, -1, 8'h00);
    master_xfer(8'h0F, 8'hC3, 1'b0, 1'b1, 1'b0, 2'd2, -1, 8'h00);
    master_xfer(8'hE2, 8'h19, 1'b1, 1'b1, 1'b1, 2'd3, -1, 8'h00);

    // R10 interrupt gating, R8 flag clear rules
    bus_write(2'd0, ctl_word(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3));
    ser_irq_en = 1'b1; #1;
    chk(irq == 1'b1, "R10 irq with all enables", irq, 1);
    ser_irq_en = 1'b0; #1;
    chk(irq == 1'b0, "R10 irq masked by external enable", irq, 0);
    ser_irq_en = 1'b1;
    bus_write(2'd0, ctl_word(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3));
    chk(irq == 1'b0, "R10 irq masked by control bit 7", irq, 0);
    bus_write(2'd0, ctl_word(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3));
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd); chk(rd[7] == 1'b1, "R8 write 0 keeps flag", rd[7], 1);
    bus_write(2'd1, 8'h80);
    bus_read(2'd1, rd); chk(rd[7] == 1'b0, "R8 write 1 clears flag", rd[7], 0);
    chk(irq == 1'b0, "R10 irq drops with flag", irq, 0);
    ser_irq_en = 1'b0;

    // R9 collision mid-transfer
    master_xfer(8'h96, 8'h5A, 1'b1, 1'b1, 1'b1, 2'd1, 6, 8'hFF);
    bus_write(2'd1, 8'h40);
    bus_read(2'd1, rd);
    chk(rd[7:6] == 2'b10, "R9 collision clear leaves completion", rd[7:6], 2);

    // R11 disable mid-transfer
    bus_write(2'd0, ctl_word(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3));
    bus_write(2'd1, 8'hC0);
    bus_write(2'd2, 8'h55);
    step(40);
    bus_write(2'd0, 8'h10);
    step(1);
    chk(!sck_oe && !mosi_oe && !miso_oe, "R11 pins released", {sck_oe, mosi_oe, miso_oe}, 0);
    step(1200);
    bus_read(2'd1, rd); chk(rd[7] == 1'b0, "R11 abort sets no completion", rd[7], 0);
    master_xfer(8'h3A, 8'hA3, 1'b0, 1'b0, 1'b0, 2'd0, -1, 8'h00);

    // random master transfers
    for (int k = 0; k < 10; k++) begin
      logic [31:0] r;
      r = $urandom;
      master_xfer(r[7:0], r[15:8], r[16], r[17], r[18], r[20:19], -1, 8'h00);
    end

    // slave transfers
    slave_xfer(8'hC5, 8'h2B, 1'b0, 1'b0, 1'b0, 2'd0);
    slave_xfer(8'h17, 8'hE8, 1'b1, 1'b0, 1'b1, 2'd2);
    slave_xfer(8'h6D, 8'h92, 1'b0, 1'b1, 1'b0, 2'd3);
    slave_xfer(8'hB4, 8'h4B, 1'b1, 1'b1, 1'b1, 2'd1);

    // R12 slave abort by select
    bus_write(2'd0, ctl_word(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0));
    bus_write(2'd1, 8'hC0);
    sck_i = 1'b0; ss_n_i = 1'b0;
    step(4);
    for (int i = 0; i < 3; i++) begin
      mosi_i = i[0];
      step(8); sck_i = 1'b1;
      step(8); sck_i = 1'b0;
    end
    step(4);
    ss_n_i = 1'b1;
    step(6);
    bus_read(2'd1, rd); chk(rd[7] == 1'b0, "R12 partial byte sets no completion", rd[7], 0);
    slave_xfer(8'h5E, 8'hA1, 1'b0, 1'b0, 1'b0, 2'd0);

    for (int k = 0; k < 3; k++) begin
      logic [31:0] r;
      r = $urandom;
      slave_xfer(r[7:0], r[15:8], r[16], r[17], r[18], r[20:19]);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule